// File: doc/BRIEF.md
# Ethernet Interrupt Flag Unit

This block collects error and completion events from the receive and transmit paths of a small Ethernet controller. It turns them into sticky flags and a single interrupt line. On the receive side it decides, in the cycle a packet arrives, whether that packet is taken or dropped. A packet is dropped when buffer space has run out, when the receive path lost its memory bandwidth, or when the pending-packet counter is already full. The counter counts accepted packets that software has not yet processed. Software lowers it with a decrement strobe once it has handled a packet.

On the transmit side the unit watches the transmit-request level and raises a done flag when that level falls. The level falls on normal completion, on an abort, and on cancellation by software. A transmit error (abort) raises the error flag, the done flag and an abort status bit together. A buffer underrun is a transmit error that also marks the buffer-error status bit.

Each of the three interrupt sources has its own enable, and a global enable gates them all. Flags that are not enabled can still be polled. Software clears any flag or status bit with a one-cycle write-one-to-clear strobe.

Top module: `eth_irq_flags`

## Requirements
- R1: While `rx_arrive` is high, `rx_drop` is high in the same cycle if `rx_no_space`, `rx_bw_short` or a full counter (255) is present. `flag_rx_err` is 1 after the next clock edge. A dropped packet does not change `pkt_count`.
- R2: `flag_rx_err`, `flag_tx_err`, `flag_tx_done`, `buf_err` and `tx_aborted` stay 1 once set, until their clear strobe or reset.
- R3: `irq` is a register. After each edge it equals `en_global` AND the OR of (`flag_rx_err`&`en_rx_err`), (`flag_tx_err`&`en_tx_err`) and (`flag_tx_done`&`en_tx_done`), taking the flag values from before that edge. With `en_global` low, `irq` is 0.
- R4: A receive arrival with `rx_bw_short` sets `buf_err` as well as `flag_rx_err`. A `tx_underrun` pulse sets `buf_err` too.
- R5: A 1-to-0 change of `tx_req`, seen at two successive clock edges, sets `flag_tx_done` at the second edge.
- R6: A `tx_error` or `tx_underrun` pulse sets `flag_tx_err`, `flag_tx_done` and `tx_aborted` at the same edge.
- R7: `pkt_count` rises by 1 for each accepted arrival and falls by 1 on `pkt_dec`. When both happen in one cycle it holds its value. A decrement at 0 leaves it at 0, and it never passes 255.
- R8: When a flag's set event and its clear strobe come in the same cycle, the flag ends up set.
- R9: During reset all flags, status bits, `irq` and `pkt_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_arrive | input | 1 | A packet is arriving this cycle |
| rx_no_space | input | 1 | Receive buffer has no room |
| rx_bw_short | input | 1 | Receive path lost memory bandwidth |
| tx_req | input | 1 | Transmit-request level |
| tx_error | input | 1 | Transmit aborted (collision, deferral, length) pulse |
| tx_underrun | input | 1 | Transmit aborted by buffer underrun pulse |
| pkt_dec | input | 1 | Software decrement of the pending count |
| clr_rx_err | input | 1 | Clear strobe, receive-error flag |
| clr_tx_err | input | 1 | Clear strobe, transmit-error flag |
| clr_tx_done | input | 1 | Clear strobe, transmit-done flag |
| clr_buf_err | input | 1 | Clear strobe, buffer-error status |
| clr_tx_abort | input | 1 | Clear strobe, abort status |
| en_global | input | 1 | Global interrupt enable |
| en_rx_err | input | 1 | Receive-error interrupt enable |
| en_tx_err | input | 1 | Transmit-error interrupt enable |
| en_tx_done | input | 1 | Transmit-done interrupt enable |
| irq | output | 1 | Combined registered interrupt |
| rx_drop | output | 1 | Reject the arriving packet |
| flag_rx_err | output | 1 | Receive-error flag |
| flag_tx_err | output | 1 | Transmit-error flag |
| flag_tx_done | output | 1 | Transmit-done flag |
| buf_err | output | 1 | Buffer-error status |
| tx_aborted | output | 1 | Abort status |
| pkt_count | output | 8 | Pending-packet count |

## Verification
The assertions assume that every event and strobe input is a clean level sampled at the clock. They also assume that `rx_no_space` and `rx_bw_short` only matter in cycles where `rx_arrive` is high. The stimulus changes every input at the falling edge only and returns each pulse to zero in the next row. The saturation test drives arrivals back to back until the counter is full. The transmit level is raised for at least one edge before it falls, so that the falling-edge detector sees a real transition.

// File: rtl/eth_irq_pkg.sv
package eth_irq_pkg;
  localparam int NUM_FLAGS   = 5;
  localparam int NUM_IRQ_SRC = 3;
  // flag vector positions; the interrupt sources occupy the low bits
  localparam int IDX_RX   = 0;
  localparam int IDX_TX   = 1;
  localparam int IDX_DONE = 2;
  localparam int IDX_BUF  = 3;
  localparam int IDX_ABT  = 4;
endpackage

// File: rtl/eirq_sticky.sv
module eirq_sticky #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;

  // hardware set takes priority over software clear
  always_comb begin
    q_nxt = set | (q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
    p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !clr[i]) |=> q[i]);
  end
endmodule

// File: rtl/eirq_pkt_cnt.sv
module eirq_pkt_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_en  = 1'b0;
    cnt_nxt = cnt;
    if (inc && !dec && cnt != CNT_MAX) begin
      cnt_en  = 1'b1;
      cnt_nxt = cnt + 1'b1;
    end else if (dec && !inc && cnt != '0) begin
      cnt_en  = 1'b1;
      cnt_nxt = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  assign full = (cnt == CNT_MAX);

  p_both_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(cnt));
  p_no_wrap_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !dec) |=> cnt == CNT_MAX);
  p_no_wrap_bot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !inc) |=> cnt == '0);
endmodule

// File: rtl/eirq_irq_out.sv
module eirq_irq_out #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] en,
  input  logic         gen,
  output logic         irq
);
  logic irq_nxt;

  always_comb begin
    irq_nxt = gen & (|(flags & en));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_nxt;
  end

  p_gate_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |=> !irq);
endmodule

// File: rtl/eth_irq_flags.sv
module eth_irq_flags
  import eth_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_arrive,
  input  logic             rx_no_space,
  input  logic             rx_bw_short,
  input  logic             tx_req,
  input  logic             tx_error,
  input  logic             tx_underrun,
  input  logic             pkt_dec,
  input  logic             clr_rx_err,
  input  logic             clr_tx_err,
  input  logic             clr_tx_done,
  input  logic             clr_buf_err,
  input  logic             clr_tx_abort,
  input  logic             en_global,
  input  logic             en_rx_err,
  input  logic             en_tx_err,
  input  logic             en_tx_done,
  output logic             irq,
  output logic             rx_drop,
  output logic             flag_rx_err,
  output logic             flag_tx_err,
  output logic             flag_tx_done,
  output logic             buf_err,
  output logic             tx_aborted,
  output logic [CNT_W-1:0] pkt_count
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1] & rst_n;

  // receive decision
  logic cnt_full, rx_fault, pkt_inc;

  always_comb begin
    rx_fault = rx_no_space | rx_bw_short | cnt_full;
    rx_drop  = rx_arrive & rx_fault;
    pkt_inc  = rx_arrive & ~rx_fault;
  end

  eirq_pkt_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .inc   (pkt_inc),
    .dec   (pkt_dec),
    .cnt   (pkt_count),
    .full  (cnt_full)
  );

  // transmit falling-edge detection
  logic tx_req_q, tx_fall, tx_fail;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) tx_req_q <= 1'b0;
    else            tx_req_q <= tx_req;
  end

  always_comb begin
    tx_fall = tx_req_q & ~tx_req;
    tx_fail = tx_error | tx_underrun;
  end

  // flag set / clear vectors
  logic [NUM_FLAGS-1:0] fl_set, fl_clr, fl_q;

  always_comb begin
    fl_set           = '0;
    fl_set[IDX_RX]   = rx_drop;
    fl_set[IDX_TX]   = tx_fail;
    fl_set[IDX_DONE] = tx_fall | tx_fail;
    fl_set[IDX_BUF]  = (rx_arrive & rx_bw_short) | tx_underrun;
    fl_set[IDX_ABT]  = tx_fail;
    fl_clr           = '0;
    fl_clr[IDX_RX]   = clr_rx_err;
    fl_clr[IDX_TX]   = clr_tx_err;
    fl_clr[IDX_DONE] = clr_tx_done;
    fl_clr[IDX_BUF]  = clr_buf_err;
    fl_clr[IDX_ABT]  = clr_tx_abort;
  end

  eirq_sticky #(.WIDTH(NUM_FLAGS)) i_flags (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set   (fl_set),
    .clr   (fl_clr),
    .q     (fl_q)
  );

  assign flag_rx_err  = fl_q[IDX_RX];
  assign flag_tx_err  = fl_q[IDX_TX];
  assign flag_tx_done = fl_q[IDX_DONE];
  assign buf_err      = fl_q[IDX_BUF];
  assign tx_aborted   = fl_q[IDX_ABT];

  logic [NUM_IRQ_SRC-1:0] src_en;
  assign src_en = {en_tx_done, en_tx_err, en_rx_err};

  eirq_irq_out #(.N(NUM_IRQ_SRC)) i_irq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .flags (fl_q[NUM_IRQ_SRC-1:0]),
    .en    (src_en),
    .gen   (en_global),
    .irq   (irq)
  );

  p_drop_flag_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_drop |=> flag_rx_err);
  p_full_drop_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_arrive && pkt_count == {CNT_W{1'b1}}) |-> rx_drop);
  p_bw_buf_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_arrive && rx_bw_short) |=> (buf_err && flag_rx_err));
  p_tx_done_fall_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_req_q && !tx_req) |=> flag_tx_done);
  p_tx_err_pair_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    tx_error |=> (flag_tx_err && flag_tx_done && tx_aborted));
endmodule

// File: tb/test_eth_irq_flags.sv
module test_eth_irq_flags;
  logic clk = 1'b0;
  logic rst_n;
  logic rx_arrive, rx_no_space, rx_bw_short, tx_req, tx_error, tx_underrun, pkt_dec;
  logic clr_rx_err, clr_tx_err, clr_tx_done, clr_buf_err, clr_tx_abort;
  logic en_global, en_rx_err, en_tx_err, en_tx_done;
  logic irq, rx_drop, flag_rx_err, flag_tx_err, flag_tx_done, buf_err, tx_aborted;
  logic [7:0] pkt_count;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  eth_irq_flags i_eth_irq_flags (
    .clk(clk), .rst_n(rst_n), .rx_arrive(rx_arrive), .rx_no_space(rx_no_space),
    .rx_bw_short(rx_bw_short), .tx_req(tx_req), .tx_error(tx_error),
    .tx_underrun(tx_underrun), .pkt_dec(pkt_dec), .clr_rx_err(clr_rx_err),
    .clr_tx_err(clr_tx_err), .clr_tx_done(clr_tx_done), .clr_buf_err(clr_buf_err),
    .clr_tx_abort(clr_tx_abort), .en_global(en_global), .en_rx_err(en_rx_err),
    .en_tx_err(en_tx_err), .en_tx_done(en_tx_done), .irq(irq), .rx_drop(rx_drop),
    .flag_rx_err(flag_rx_err), .flag_tx_err(flag_tx_err), .flag_tx_done(flag_tx_done),
    .buf_err(buf_err), .tx_aborted(tx_aborted), .pkt_count(pkt_count)
  );

  // flag and clear order: {rx_err, tx_err, tx_done, buf_err, abort}; en: {global, rx, tx, done}
  typedef struct packed {
    bit       arr, nosp, bw, txr, txe, und;
    bit [4:0] clr;
    bit       dec;
    bit [3:0] en;
    bit [4:0] ef;
    bit       edrop;
    bit [7:0] ecnt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1,0,0,0,0,0,5'b00000,0,4'b0000,5'b00000,1'b0,8'd1},  // R7 accept
    '{1,1,0,0,0,0,5'b00000,0,4'b0000,5'b10000,1'b1,8'd1},  // R1 no space
    '{1,0,1,0,0,0,5'b00000,0,4'b1100,5'b10010,1'b1,8'd1},  // R1 R4 bandwidth
    '{0,0,0,0,0,0,5'b10010,0,4'b1100,5'b00000,1'b0,8'd1},  // R2 clear
    '{0,0,0,1,0,0,5'b00000,0,4'b1100,5'b00000,1'b0,8'd1},  // tx request up
    '{0,0,0,0,0,0,5'b00000,0,4'b1100,5'b00100,1'b0,8'd1},  // R5 fall
    '{0,0,0,0,0,0,5'b00000,0,4'b1101,5'b00100,1'b0,8'd1},  // R2 hold, R3
    '{0,0,0,0,1,1,5'b00100,0,4'b1101,5'b01111,1'b0,8'd1},  // R6 R8 R4
    '{0,0,0,0,0,0,5'b01111,0,4'b1000,5'b00000,1'b0,8'd1},  // R2 clears
    '{1,0,0,0,0,0,5'b00000,1,4'b1000,5'b00000,1'b0,8'd1},  // R7 both hold
    '{0,0,0,0,0,0,5'b00000,1,4'b1000,5'b00000,1'b0,8'd0},  // R7 decrement
    '{0,0,0,0,0,0,5'b00000,1,4'b1000,5'b00000,1'b0,8'd0}   // R7 floor
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    {rx_arrive, rx_no_space, rx_bw_short, tx_error, tx_underrun, pkt_dec} = '0;
    {clr_rx_err, clr_tx_err, clr_tx_done, clr_buf_err, clr_tx_abort} = '0;
  endtask

  function automatic int flags5();
    return int'({flag_rx_err, flag_tx_err, flag_tx_done, buf_err, tx_aborted});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit [4:0] pf;
    rst_n = 1'b0;
    idle();
    tx_req = 1'b0;
    {en_global, en_rx_err, en_tx_err, en_tx_done} = '0;
    repeat (3) @(negedge clk);
    check("R9 flags in reset", flags5(), 0);
    check("R9 irq in reset", int'(irq), 0);
    check("R9 count in reset", int'(pkt_count), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    pf = '0;
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      bit   eirq;
      v = VECS[i];
      {rx_arrive, rx_no_space, rx_bw_short, tx_req, tx_error, tx_underrun} =
        {v.arr, v.nosp, v.bw, v.txr, v.txe, v.und};
      {clr_rx_err, clr_tx_err, clr_tx_done, clr_buf_err, clr_tx_abort} = v.clr;
      pkt_dec = v.dec;
      {en_global, en_rx_err, en_tx_err, en_tx_done} = v.en;
      eirq = v.en[3] & ((pf[4] & v.en[2]) | (pf[3] & v.en[1]) | (pf[2] & v.en[0]));
      #1;
      check($sformatf("R1 drop row %0d", i), int'(rx_drop), int'(v.edrop));
      @(negedge clk);
      check($sformatf("R2 R6 R8 flags row %0d", i), flags5(), int'(v.ef));
      check($sformatf("R7 count row %0d", i), int'(pkt_count), int'(v.ecnt));
      check($sformatf("R3 irq row %0d", i), int'(irq), int'(eirq));
      pf = v.ef;
    end
    idle();

    // R3: global enable gates the interrupt
    {en_global, en_rx_err, en_tx_err, en_tx_done} = 4'b0100;
    rx_arrive = 1'b1; rx_no_space = 1'b1;
    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    check("R3 gated by global", int'(irq), 0);
    check("R2 polled flag", int'(flag_rx_err), 1);
    en_global = 1'b1;
    @(negedge clk);
    check("R3 irq after global enable", int'(irq), 1);

    // R2: hold for a long idle stretch, then clear
    repeat (20) @(negedge clk);
    check("R2 still set", int'(flag_rx_err), 1);
    clr_rx_err = 1'b1;
    @(negedge clk);
    idle();
    check("R2 cleared", int'(flag_rx_err), 0);
    @(negedge clk);
    check("R3 irq drops", int'(irq), 0);

    // R7 saturation and R1 full-counter drop
    rx_arrive = 1'b1;
    repeat (255) @(negedge clk);
    check("R7 count full", int'(pkt_count), 255);
    #1;
    check("R1 drop when full", int'(rx_drop), 1);
    @(negedge clk);
    check("R7 no wrap", int'(pkt_count), 255);
    check("R1 flag when full", int'(flag_rx_err), 1);
    pkt_dec = 1'b1;
    #1;
    check("R1 drop full with dec", int'(rx_drop), 1);
    @(negedge clk);
    check("R7 dec while full arrive", int'(pkt_count), 254);
    rx_arrive = 1'b0;
    @(negedge clk);
    idle();
    check("R7 dec", int'(pkt_count), 253);

    // R9: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    check("R9 count async reset", int'(pkt_count), 0);
    check("R9 flags async reset", flags5(), 0);
    check("R9 irq async reset", int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule